// File: doc/BRIEF.md
# Polled MDIO Management Master

This block issues one management-bus transaction to an external PHY for each command that software writes into a single 32-bit control word. The word carries the operation, the PHY and register addresses and, for a write, the 16 data bits. When a command is accepted, the block raises a busy flag. It then builds the serial frame and shifts it out on a management clock divided down from the system clock. On a read it releases the data line for the turnaround and collects the PHY's reply. When the frame is done it drops busy.

Software starts a transaction with a single write and polls busy until it reads 0. After a read, the low half of the same control word holds the returned value. Only a small range of PHY addresses is reachable, and a command aimed outside that range is never started.

Top module: `mdio_master`

## Requirements
- R1: After a synchronous active-low reset, `ctl_rdata` is 0, `busy` is 0, `mdc` is 0 and `mdio_oe` is 0.
- R2: Control word layout: bits [15:0] data, [20:16] register number, [25:21] PHY address, bit 27 operation (1 read, 0 write), bit 30 enable, bit 31 busy. Bits 26, 28 and 29 always read 0. An accepted write stores every other field and reads back at once.
- R3: A write while idle starts a frame only if bit 31 and bit 30 are both 1 and the PHY address is below NUM_PHYS (5). Otherwise busy reads 0 and `mdc` stays low.
- R4: A write frame is 64 bits, sent MSB first: 32 ones, start 01, opcode 01, 5-bit PHY address, 5-bit register, turnaround 10, then the 16 data bits.
- R5: A read frame sends 32 ones, start 01, opcode 10, PHY address and register, in that order.
- R6: `mdio_oe` is high for the whole of a write frame. In a read frame it is high for bits 0 to 45 and low from bit 46 (first turnaround bit) to the end. It is never high while idle.
- R7: On a read, `mdio_i` is sampled at the rising edges of `mdc` in bits 48 to 63, MSB first. The 16 values replace bits [15:0] of the control word when busy clears, and the other fields are kept.
- R8: After a write completes, bits [15:0] still hold the written data and busy reads 0.
- R9: `mdc` is low while idle and toggles every MDC_HALF_CYCLES system clocks while busy. Busy stays 1 for exactly 128 × MDC_HALF_CYCLES cycles after the accepting edge.
- R10: A control write sampled while busy is 1 is ignored. This includes the cycle in which the frame completes: the word, the frame in progress and its length are unchanged, and no new frame starts.
- R11: `mdio_o` changes only while `mdc` is low. It is updated at falling edges and held steady across each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 32 | Control word to write |
| ctl_rdata | output | 32 | Current control word |
| busy | output | 1 | Transaction in progress (control bit 31) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Serial data returned by the PHY |

## Verification
Two events can land in the same cycle: the final falling edge of a frame, which clears busy and loads read data, and a new control write from software. The bench times a valid start command so that it is sampled exactly on that completing edge. It expects the write to be dropped: the control word must show the just-captured read data with busy at 0, and `mdc` must stay quiet afterwards. A second case places the intruding write in the middle of a frame and expects the transmitted bits and the frame length to be unaffected.

// File: rtl/mdio_pkg.sv
// Package: field positions of the control word, frame geometry and the
// command record shared by the register, the frame engine and the top.
// Assumes a 64-bit management frame (32-bit preamble included).
package mdio_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned DATA_W      = 16;
    localparam int unsigned ADDR_W      = 5;
    localparam int unsigned PREAMBLE_W  = 32;
    localparam int unsigned FRAME_BITS  = PREAMBLE_W + 4 + 2 * ADDR_W + 2 + DATA_W;
    localparam int unsigned TA_FIRST    = FRAME_BITS - DATA_W - 2;
    localparam int unsigned DATA_FIRST  = FRAME_BITS - DATA_W;

    localparam int unsigned BIT_BUSY    = 31;
    localparam int unsigned BIT_EN      = 30;
    localparam int unsigned BIT_RD      = 27;
    localparam int unsigned PHY_LSB     = 21;
    localparam int unsigned REG_LSB     = 16;

    // Bits that a write may set; reserved bits always read 0.
    localparam logic [WORD_W-1:0] WRITABLE =
        (WORD_W'(1) << BIT_BUSY) | (WORD_W'(1) << BIT_EN) |
        (WORD_W'(1) << BIT_RD)   | (WORD_W'({ADDR_W{1'b1}}) << PHY_LSB) |
        (WORD_W'({ADDR_W{1'b1}}) << REG_LSB) | WORD_W'({DATA_W{1'b1}});

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
        logic [DATA_W-1:0] data;
    } mdio_cmd_t;

    // Assemble the full serial frame, first bit in the MSB.
    function automatic logic [FRAME_BITS-1:0] mdio_frame(input mdio_cmd_t c);
        logic [1:0] opc;
        opc = c.rd ? 2'b10 : 2'b01;
        return {{PREAMBLE_W{1'b1}}, 2'b01, opc, c.phy, c.regn, 2'b10,
                c.rd ? {DATA_W{1'b0}} : c.data};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
// Module: management clock divider.
// Produces MDC at HALF_CYCLES system clocks per phase while run is high,
// holding MDC low otherwise. rise_stb / fall_stb are high in the system
// cycle whose closing edge moves MDC high / low.
// Assumes run rises together with the start of a frame.
module mdio_clkgen #(
    parameter int unsigned HALF_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int unsigned CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;

    logic [CW-1:0] phase_cnt;
    logic          wrap;

    assign wrap     = run && (phase_cnt == CW'(HALF_CYCLES - 1));
    assign rise_stb = wrap && !mdc;
    assign fall_stb = wrap &&  mdc;

    // Phase counter and MDC toggle; both parked at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_cnt <= '0;
            mdc       <= 1'b0;
        end else if (wrap) begin
            phase_cnt <= '0;
            mdc       <= ~mdc;
        end else begin
            phase_cnt <= phase_cnt + CW'(1);
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Module: serial frame engine.
// Loads the whole frame on start, shifts it MSB first at each MDC falling
// edge, releases the line from the first turnaround bit of a read and
// gathers the 16 reply bits at rising edges. done pulses in the cycle that
// ends the last bit. Assumes start is only given while inactive.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              active,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_value
);
    localparam int unsigned IW = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] shreg;
    logic [IW-1:0]         bit_idx;
    logic                  is_rd;
    logic                  last_bit;

    assign last_bit = (bit_idx == IW'(FRAME_BITS - 1));
    assign done     = active && fall_stb && last_bit;
    assign mdio_o   = shreg[FRAME_BITS-1];
    assign mdio_oe  = active && !(is_rd && (bit_idx >= IW'(TA_FIRST)));

    // Frame sequencing: load, shift on falling edges, stop after last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            shreg   <= '0;
            bit_idx <= '0;
            is_rd   <= 1'b0;
        end else if (start && !active) begin
            active  <= 1'b1;
            shreg   <= mdio_frame(cmd);
            bit_idx <= '0;
            is_rd   <= cmd.rd;
        end else if (active && fall_stb) begin
            if (last_bit) begin
                active <= 1'b0;
            end else begin
                bit_idx <= bit_idx + IW'(1);
                shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    // Reply capture: sample the line at rising edges of the data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_value <= '0;
        end else if (active && rise_stb && is_rd && (bit_idx >= IW'(DATA_FIRST))) begin
            rd_value <= {rd_value[DATA_W-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_ctl_reg.sv
// Module: control word.
// Accepts a software write only while busy is clear, decides whether it
// starts a frame, and on completion clears busy and, for reads, returns the
// captured data in the low half. Assumes done only arrives while busy.
module mdio_ctl_reg
    import mdio_pkg::*;
#(
    parameter int unsigned NUM_PHYS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_value,
    output logic [WORD_W-1:0] word,
    output logic              start,
    output mdio_cmd_t         cmd
);
    logic accept;
    logic phy_ok;

    assign accept = wr_en && !word[BIT_BUSY];
    assign phy_ok = int'(wr_data[PHY_LSB +: ADDR_W]) < int'(NUM_PHYS);
    assign start  = accept && wr_data[BIT_BUSY] && wr_data[BIT_EN] && phy_ok;

    // Command record handed to the frame engine together with start.
    always_comb begin
        cmd.rd   = wr_data[BIT_RD];
        cmd.phy  = wr_data[PHY_LSB +: ADDR_W];
        cmd.regn = wr_data[REG_LSB +: ADDR_W];
        cmd.data = wr_data[DATA_W-1:0];
    end

    // Word storage: software load when idle, completion update when done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (accept) begin
            word           <= wr_data & WRITABLE;
            word[BIT_BUSY] <= start;
        end else if (done) begin
            word[BIT_BUSY] <= 1'b0;
            if (word[BIT_RD]) begin
                word[DATA_W-1:0] <= rd_value;
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
// Module: polled management-bus master (top).
// Joins the control word, the clock divider and the frame engine. Software
// writes one command word, polls busy, and reads back the result.
// Assumes the data line is resolved outside from mdio_o / mdio_oe.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int unsigned MDC_HALF_CYCLES = 5,
    parameter int unsigned NUM_PHYS        = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic [31:0] ctl_wdata,
    output logic [31:0] ctl_rdata,
    output logic        busy,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              start;
    logic              active;
    logic              done;
    logic              rise_stb;
    logic              fall_stb;
    logic [DATA_W-1:0] rd_value;
    mdio_cmd_t         cmd;
    logic [WORD_W-1:0] word;

    assign ctl_rdata = word;
    assign busy      = word[BIT_BUSY];

    mdio_ctl_reg #(
        .NUM_PHYS (NUM_PHYS)
    ) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctl_wr),
        .wr_data  (ctl_wdata),
        .done     (done),
        .rd_value (rd_value),
        .word     (word),
        .start    (start),
        .cmd      (cmd)
    );

    mdio_clkgen #(
        .HALF_CYCLES (MDC_HALF_CYCLES)
    ) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (active),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (cmd),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .active   (active),
        .done     (done),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_value (rd_value)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Module: protocol checker bound to mdio_master.
// Watches the pins and the control word for idle, drive, hold and timing
// rules. Assumes synchronous active-low reset.
module mdio_master_chk #(
    parameter int unsigned HALF = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic [31:0] ctl_rdata
);
    localparam int unsigned GW = $clog2(HALF + 2) + 1;

    logic          mdc_q;
    logic [GW-1:0] gap;
    logic          seen;

    // Cycles since the last MDC change, and whether a change was seen in a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_q <= 1'b0;
            gap   <= '0;
            seen  <= 1'b0;
        end else begin
            mdc_q <= mdc;
            if (mdc != mdc_q) begin
                gap  <= GW'(1);
                seen <= busy;
            end else if (gap != '1) begin
                gap <= gap + GW'(1);
            end
        end
    end

    p_mdc_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    p_mdc_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mdc != mdc_q) && seen) |-> (gap == GW'(HALF)));

    p_oe_within_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);

    p_word_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ctl_rdata));

    p_data_on_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> !mdc);
endmodule

bind mdio_master mdio_master_chk #(
    .HALF (MDC_HALF_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .ctl_rdata (ctl_rdata)
);

// File: tb/tb_mdio_master.sv
// Bench: sweeps PHY addresses 0..7 with both operations, plus disabled,
// boundary, mid-frame and completion-cycle intrusion cases. A behavioural
// PHY records the frame and returns a known reply.
module tb_mdio_master;
    localparam int HALF = 2;
    localparam int NPHY = 5;
    localparam int FRAME_CYC = 128 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        busy, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mdio_master #(.MDC_HALF_CYCLES(HALF), .NUM_PHYS(NPHY)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i));

    // PHY model state
    int          rise_k = 0;
    int          oe_err = 0;
    int          hold_err = 0;
    logic [63:0] obs = '0;
    logic [15:0] resp = '0;
    logic        cur_rd = 1'b0;
    logic        held = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Record each bit at the MDC rising edge and check the drive enable.
    always @(posedge mdc) begin
        if (rise_k < 64) obs[63 - rise_k] = mdio_o;
        if (cur_rd && rise_k >= 46) begin
            if (mdio_oe !== 1'b0) oe_err++;
        end else if (mdio_oe !== 1'b1) oe_err++;
        held = mdio_o;
        rise_k++;
    end

    // Reply bits placed on the line after each falling edge.
    always @(negedge mdc) begin
        if (rise_k >= 48 && rise_k < 64) mdio_i = resp[63 - rise_k];
    end

    // Data line must not move while MDC is high.
    always @(negedge clk) begin
        if (rst_n && mdc && (mdio_o !== held)) hold_err++;
    end

    task automatic run_cmd(input logic [4:0] phy, input logic [4:0] rn, input bit rd,
                           input logic [15:0] wd, input logic [15:0] rsp, input bit en,
                           input int intrude_at);
        logic [31:0] wr_word, exp_word;
        logic [63:0] exp_frame;
        bit          go;
        int          cyc;
        go = en && (phy < NPHY);
        resp = rsp; cur_rd = rd; rise_k = 0; oe_err = 0; hold_err = 0; obs = '0;
        wr_word  = {1'b1, en, 2'b11, rd, 1'b1, phy, rn, wd};
        exp_word = {1'b0, en, 2'b00, rd, 1'b0, phy, rn, (go && rd) ? rsp : wd};
        exp_frame = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rn, 2'b10, wd};
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = wr_word;
        @(negedge clk); ctl_wr = 1'b0;
        check(busy == go, "R3 busy after start", 64'(busy), 64'(go));
        if (go) begin
            check(ctl_rdata == (exp_word | 32'h8000_0000) || rd,
                  "R2 readback while busy", 64'(ctl_rdata), 64'(exp_word | 32'h8000_0000));
            cyc = 0;
            while (busy && cyc < 4000) begin
                if (intrude_at != 0 && cyc == intrude_at) begin
                    ctl_wr = 1'b1;
                    ctl_wdata = {1'b1, 1'b1, 4'b0000, 5'd1, 5'd3, 16'h1234} | 32'h0800_0000;
                end
                @(negedge clk);
                ctl_wr = 1'b0;
                if (intrude_at != 0 && cyc == intrude_at && busy)
                    check(ctl_rdata[26:0] == wr_word[26:0] - {wr_word[26], 26'b0},
                          "R10 word unchanged after busy write", 64'(ctl_rdata), 64'(wr_word));
                cyc++;
            end
            check(cyc == FRAME_CYC, "R9 busy length", 64'(cyc), 64'(FRAME_CYC));
            check(rise_k == 64, "R9 MDC rising edges", 64'(rise_k), 64'd64);
            if (rd) check(obs[63:18] == exp_frame[63:18], "R5 read frame header", obs, exp_frame);
            else    check(obs == exp_frame, "R4 write frame", obs, exp_frame);
            check(oe_err == 0, "R6 drive enable", 64'(oe_err), 64'd0);
            check(hold_err == 0, "R11 data stable while MDC high", 64'(hold_err), 64'd0);
            check(ctl_rdata == exp_word, rd ? "R7 read result" : "R8 write result",
                  64'(ctl_rdata), 64'(exp_word));
            repeat (40) @(negedge clk);
            check(!busy && rise_k == 64 && !mdc, "R10 no restart after frame",
                  64'(rise_k), 64'd64);
        end else begin
            repeat (40) @(negedge clk);
            check(rise_k == 0 && !mdc, "R3 no MDC activity", 64'(rise_k), 64'd0);
            check(ctl_rdata == exp_word, "R2 stored fields, reserved zero",
                  64'(ctl_rdata), 64'(exp_word));
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(ctl_rdata == 0 && !busy && !mdc && !mdio_oe, "R1 reset state",
              64'(ctl_rdata), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ctl_rdata == 0 && !busy && !mdc && !mdio_oe, "R1 state after release",
              64'(ctl_rdata), 64'd0);
        // Sweep PHY addresses (5..7 rejected) with both operations.
        for (int p = 0; p < 8; p++) begin
            for (int o = 0; o < 2; o++) begin
                run_cmd(5'(p), 5'((p * 11 + o * 5 + 3) % 32), bit'(o),
                        16'hA5C3 ^ 16'(p << 8) ^ (o != 0 ? 16'h0F0F : 16'h0000),
                        16'h8001 ^ 16'(p * 16'h1111), 1'b1, 0);
            end
        end
        // Enable bit clear: nothing starts.
        run_cmd(5'd2, 5'd9, 1'b0, 16'h5A5A, 16'h0, 1'b0, 0);
        // Boundary fields.
        run_cmd(5'd0, 5'd31, 1'b1, 16'h0000, 16'hFFFF, 1'b1, 0);
        run_cmd(5'd4, 5'd0, 1'b0, 16'hFFFF, 16'h0, 1'b1, 0);
        run_cmd(5'd3, 5'd0, 1'b0, 16'h0000, 16'h0, 1'b1, 0);
        // Intruding write in mid frame, then on the completion edge.
        run_cmd(5'd2, 5'd17, 1'b0, 16'h3C96, 16'h0, 1'b1, 37);
        run_cmd(5'd4, 5'd22, 1'b1, 16'h0, 16'h6B2D, 1'b1, FRAME_CYC - 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule